// File: doc/BRIEF.md
# Sector Write-Permission Guard

This block keeps the protection state of a flash array split into 64-Kbyte sectors, and it decides whether a program or erase request may go ahead. Commands arrive on a one-cycle command strobe. They can protect or unprotect one sector, protect or unprotect every sector at once, or lock one sector down for good. An active-low write-protect input freezes protection: while it is low, no protected sector can lose its protection. The non-volatile bits are modelled as registers. The synchronous reset stands for power-up initialisation.

A permit query gives a 24-bit byte address and an erase size: 4K, 32K, 64K or full chip. A plain program uses any of the non-chip sizes. One cycle later the block returns a registered allow or deny. A query is judged against the state that held before any command strobed in the same cycle.

Top module: `sector_guard`

## Requirements
- R1: After reset, every sector's protect bit is set and every lockdown bit is clear, `rsp_valid` and `rsp_allow` are low, and so any non-chip query is denied.
- R2: `cmd_op` = 1 sets the protect bit of sector `cmd_sector`, and `cmd_op` = 2 clears it. No other sector changes.
- R3: `cmd_op` = 5 sets the lockdown bit of sector `cmd_sector`. No command clears a lockdown bit; only reset does.
- R4: `cmd_op` = 3 sets every protect bit, and `cmd_op` = 4 clears every protect bit. Lockdown bits are not affected.
- R5: While `wp_n` is low, ops 2 and 4 change no protect bit. Op 1 and op 3 still set protect bits.
- R6: A query with `chk_size` 0 (4K), 1 (32K) or 2 (64K) is allowed only if the sector `chk_addr[22:16]` has neither its protect bit nor its lockdown bit set. `chk_addr[23]` and `chk_addr[15:0]` are ignored.
- R7: A query with `chk_size` 3 (full chip) is allowed only if no sector has its protect bit or its lockdown bit set.
- R8: A query made with `chk_valid` high gives `rsp_valid` high on the next cycle, with `rsp_allow` on the same cycle. Without a query, `rsp_valid` and `rsp_allow` are low on the next cycle.
- R9: A query and a command in the same cycle: the query is judged on the state before the command, and the command still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up initialisation) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 protect, 2 unprotect, 3 protect all, 4 unprotect all, 5 lockdown |
| cmd_sector | input | 7 | Target sector of single-sector commands |
| wp_n | input | 1 | Write-protect, active low |
| chk_valid | input | 1 | Permit query strobe |
| chk_addr | input | 24 | Byte address of the query |
| chk_size | input | 2 | 0 4K, 1 32K, 2 64K, 3 full chip |
| rsp_valid | output | 1 | Registered query response strobe |
| rsp_allow | output | 1 | Registered permission, high means allowed |

## Verification
A command that changes a sector's state and a permit query on that same sector can land in one cycle. The bench provokes this by driving an unprotect of a protected sector together with a query on that sector. The response must show the old state, a deny. A second query right after must then be allowed, which shows the command was not lost. Unprotect requests made while `wp_n` is low are judged the same way: they must leave the sector denied.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_PROT_ONE = 3'd1,
    OP_FREE_ONE = 3'd2,
    OP_PROT_ALL = 3'd3,
    OP_FREE_ALL = 3'd4,
    OP_LOCK_ONE = 3'd5
  } guard_op_e;

  typedef enum logic [1:0] {
    SZ_4K   = 2'd0,
    SZ_32K  = 2'd1,
    SZ_64K  = 2'd2,
    SZ_CHIP = 2'd3
  } erase_sz_e;
endpackage

// File: rtl/protect_bank.sv
module protect_bank #(
  parameter int SECTORS = 128,
  parameter int SECT_W  = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [SECT_W-1:0]  cmd_sector,
  input  logic               wp_n,
  output logic [SECTORS-1:0] prot_q
);
  import guard_pkg::*;

  guard_op_e op;
  assign op = guard_op_e'(cmd_op);

  for (genvar i = 0; i < SECTORS; i++) begin : g_sect
    localparam logic [SECT_W-1:0] IDX = SECT_W'(i);
    logic hit;
    assign hit = (cmd_sector == IDX);
    always_ff @(posedge clk) begin
      if (rst) begin
        prot_q[i] <= 1'b1;
      end else if (cmd_valid) begin
        case (op)
          OP_PROT_ONE: if (hit) prot_q[i] <= 1'b1;
          OP_FREE_ONE: if (hit && wp_n) prot_q[i] <= 1'b0;
          OP_PROT_ALL: prot_q[i] <= 1'b1;
          OP_FREE_ALL: if (wp_n) prot_q[i] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lock_bank.sv
module lock_bank #(
  parameter int SECTORS = 128,
  parameter int SECT_W  = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [SECT_W-1:0]  cmd_sector,
  output logic [SECTORS-1:0] lock_q
);
  import guard_pkg::*;

  logic set_req;
  assign set_req = cmd_valid && (guard_op_e'(cmd_op) == OP_LOCK_ONE);

  for (genvar i = 0; i < SECTORS; i++) begin : g_sect
    localparam logic [SECT_W-1:0] IDX = SECT_W'(i);
    always_ff @(posedge clk) begin
      if (rst) lock_q[i] <= 1'b0;
      else if (set_req && cmd_sector == IDX) lock_q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/permit_eval.sv
module permit_eval #(
  parameter int SECTORS  = 128,
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SECTORS-1:0] prot_q,
  input  logic [SECTORS-1:0] lock_q,
  input  logic               chk_valid,
  input  logic [ADDR_W-1:0]  chk_addr,
  input  logic [1:0]         chk_size,
  output logic               rsp_valid,
  output logic               rsp_allow
);
  import guard_pkg::*;

  logic [SECT_W-1:0]  idx;
  logic [SECTORS-1:0] barred;
  logic               ok_next;

  assign idx    = chk_addr[SECT_LSB +: SECT_W];
  assign barred = prot_q | lock_q;

  always_comb begin
    if (erase_sz_e'(chk_size) == SZ_CHIP) ok_next = ~(|barred);
    else                                  ok_next = ~barred[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= chk_valid;
      rsp_allow <= chk_valid && ok_next;
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int SECTORS  = 128,
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [2:0]                  cmd_op,
  input  logic [$clog2(SECTORS)-1:0]  cmd_sector,
  input  logic                        wp_n,
  input  logic                        chk_valid,
  input  logic [ADDR_W-1:0]           chk_addr,
  input  logic [1:0]                  chk_size,
  output logic                        rsp_valid,
  output logic                        rsp_allow
);
  localparam int SECT_W = $clog2(SECTORS);

  logic [SECTORS-1:0] prot_bits;
  logic [SECTORS-1:0] lock_bits;

  protect_bank #(.SECTORS(SECTORS), .SECT_W(SECT_W)) u_prot (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .wp_n(wp_n), .prot_q(prot_bits)
  );

  lock_bank #(.SECTORS(SECTORS), .SECT_W(SECT_W)) u_lock (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .lock_q(lock_bits)
  );

  permit_eval #(.SECTORS(SECTORS), .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W)) u_eval (
    .clk(clk), .rst(rst), .prot_q(prot_bits), .lock_q(lock_bits),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_size(chk_size),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
  );
endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int SECTORS  = 128,
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [2:0]         cmd_op,
  input logic               wp_n,
  input logic               chk_valid,
  input logic [ADDR_W-1:0]  chk_addr,
  input logic [1:0]         chk_size,
  input logic               rsp_valid,
  input logic               rsp_allow,
  input logic [SECTORS-1:0] prot_q,
  input logic [SECTORS-1:0] lock_q
);
  localparam int SECT_W = $clog2(SECTORS);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (($past(lock_q) & ~lock_q) == '0));

  p_wp_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(wp_n) |-> (($past(prot_q) & ~prot_q) == '0));

  p_chip_deny_r7: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_size == 2'd3 && ((prot_q | lock_q) != '0)) |=> !rsp_allow);

  p_sector_deny_r6: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_size != 2'd3 && lock_q[chk_addr[SECT_LSB +: SECT_W]]) |=> !rsp_allow);

  p_rsp_follow_r8: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> rsp_valid);

  p_rsp_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> (!rsp_valid && !rsp_allow));

  p_free_all_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd4 && wp_n) |=> (prot_q == '0));
endmodule

bind sector_guard guard_checker #(.SECTORS(SECTORS), .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wp_n(wp_n),
  .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_size(chk_size),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
  .prot_q(prot_bits), .lock_q(lock_bits)
);

// File: tb/tb_sector_guard.sv
module tb_sector_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [6:0]  cmd_sector = 7'd0;
  logic        wp_n = 1'b1;
  logic        chk_valid = 1'b0;
  logic [23:0] chk_addr = 24'd0;
  logic [1:0]  chk_size = 2'd0;
  logic        rsp_valid;
  logic        rsp_allow;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_guard dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .wp_n(wp_n), .chk_valid(chk_valid),
    .chk_addr(chk_addr), .chk_size(chk_size),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
  );

  function automatic logic [23:0] addr_of(input int sec, input int off);
    return {1'b0, 7'(sec), 16'(off)};
  endfunction

  task automatic expect_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic do_cmd(input int op, input int sec);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_sector = 7'(sec);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic query(input string tag, input logic [23:0] a, input int sz, input logic exp);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = a; chk_size = 2'(sz);
    @(negedge clk);
    chk_valid = 1'b0;
    expect_bit({tag, " valid"}, rsp_valid, 1'b1);
    expect_bit({tag, " allow"}, rsp_allow, exp);
  endtask

  task automatic apply_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    expect_bit("R1 rsp_valid after reset", rsp_valid, 1'b0);
    expect_bit("R1 rsp_allow after reset", rsp_allow, 1'b0);
    query("R1 sector0 protected", addr_of(0, 0), 0, 1'b0);
    query("R1 sector127 protected", addr_of(127, 16'hFFFF), 2, 1'b0);
  endtask

  task automatic t_global_and_single();
    do_cmd(4, 0);
    query("R4 free all sector3", addr_of(3, 16'h1234), 1, 1'b1);
    query("R7 chip allowed when clear", addr_of(0, 0), 3, 1'b1);
    do_cmd(1, 5);
    query("R2 sector5 4K denied", addr_of(5, 16'h0100), 0, 1'b0);
    query("R6 sector5 32K denied", addr_of(5, 16'h8000), 1, 1'b0);
    query("R2 sector6 untouched", addr_of(6, 0), 2, 1'b1);
    query("R2 sector4 untouched", addr_of(4, 16'hFFFF), 0, 1'b1);
    query("R7 chip denied one protected", addr_of(0, 0), 3, 1'b0);
    query("R6 bit23 ignored", addr_of(5, 0) | 24'h800000, 0, 1'b0);
    do_cmd(2, 5);
    query("R2 sector5 unprotected", addr_of(5, 0), 2, 1'b1);
    do_cmd(3, 0);
    query("R4 protect all sector90", addr_of(90, 0), 0, 1'b0);
    do_cmd(4, 0);
  endtask

  task automatic t_write_protect();
    do_cmd(1, 9);
    @(negedge clk); wp_n = 1'b0;
    do_cmd(2, 9);
    query("R5 single unprotect blocked", addr_of(9, 0), 0, 1'b0);
    do_cmd(4, 0);
    query("R5 global unprotect blocked", addr_of(9, 0), 2, 1'b0);
    do_cmd(1, 10);
    query("R5 protect still works", addr_of(10, 0), 0, 1'b0);
    query("R5 other sector free", addr_of(11, 0), 0, 1'b1);
    @(negedge clk); wp_n = 1'b1;
    do_cmd(4, 0);
    query("R5 unprotect after release", addr_of(9, 0), 0, 1'b1);
    query("R5 sector10 after release", addr_of(10, 0), 1, 1'b1);
  endtask

  task automatic t_lockdown();
    do_cmd(5, 20);
    query("R3 locked sector denied", addr_of(20, 0), 0, 1'b0);
    do_cmd(4, 0);
    do_cmd(2, 20);
    query("R3 lock survives unprotect", addr_of(20, 16'h4000), 2, 1'b0);
    query("R7 chip denied by lock", addr_of(0, 0), 3, 1'b0);
    query("R6 neighbour of lock free", addr_of(21, 0), 0, 1'b1);
    apply_reset();
    do_cmd(4, 0);
    query("R3 reset clears lock", addr_of(20, 0), 0, 1'b1);
  endtask

  task automatic t_collision();
    do_cmd(1, 30);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_sector = 7'd30;
    chk_valid = 1'b1; chk_addr = addr_of(30, 0); chk_size = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; chk_valid = 1'b0;
    expect_bit("R9 same-cycle valid", rsp_valid, 1'b1);
    expect_bit("R9 same-cycle old state", rsp_allow, 1'b0);
    query("R9 command took effect", addr_of(30, 0), 0, 1'b1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    expect_bit("R8 idle rsp_valid", rsp_valid, 1'b0);
    expect_bit("R8 idle rsp_allow", rsp_allow, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_global_and_single();
    t_write_protect();
    t_lockdown();
    t_collision();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule